// File: doc/BRIEF.md
# Fixed-Slot Wide-Bundle Execution Engine

This engine takes one wide instruction bundle per clock and sends all six of its operation slots to dedicated functional units in parallel. Two slots feed integer ALUs. Two feed load/store units that share a small internal data memory. The last two feed an adder and a multiplier, which stand in for floating-point units and use 32-bit integer arithmetic. All units write back into one shared multi-ported register file of 32 entries of 32 bits.

Each unit has a fixed latency that software can see: integer 1 cycle, load/store 3 cycles, arithmetic 4 cycles. The engine contains no scoreboard, interlock, stall or reordering. Correct placement of operations is the scheduler's job. A consumer issued too early reads the old register value, and that behaviour is defined.

Bundles arrive on a valid/ready stream. `bundle_ready` is high in every cycle outside reset, because the engine never applies back-pressure. A bundle issues on each rising edge where both `bundle_valid` and `bundle_ready` are high. A cycle with `bundle_valid` low is a bubble. A debug port reads any register combinationally. A registered branch output reports a taken compare-not-equal branch together with its displacement.

Top module: `vliw_bundle_engine`

## Requirements
- R1: The bundle is 144 bits and holds six 24-bit slots. Slot k occupies bits [24k+23:24k]. The slot order is 0 = int A, 1 = int B, 2 = mem A, 3 = mem B, 4 = adder, 5 = multiplier. Each slot is laid out as {opcode[23:20], rd[19:15], rs1[14:10], rs2[9:5], imm[4:0]}, where imm is a signed 5-bit value.
- R2: `bundle_ready` is 1 in every cycle outside reset. A bundle with `bundle_valid` low has no effect on registers, memory or the branch output.
- R3: The integer slots support ADD=1 (rs1+rs2), SUB=2, AND=3, OR=4, XOR=5 and ADDI=6 (rs1+imm). Their result is visible to the very next bundle.
- R4: The memory slots support LD=8 (rd = mem[rs1+imm]) and ST=9 (mem[rs1+imm] = rs2). Word addresses wrap modulo 16. A load result reaches rd 3 cycles after issue. A store writes memory 3 cycles after issue, so a load issued together with that store still reads the old word, while a load issued one cycle later reads the new word.
- R5: The adder slot supports opcode 10 (rs1+rs2) and the multiplier slot supports opcode 11 (low 32 bits of rs1*rs2). The result reaches rd 4 cycles after issue.
- R6: Every slot reads its sources at issue, before any write from its own bundle takes effect.
- R7: There is no interlock. A read made before the producer's latency has elapsed returns the old value, and bundles keep issuing one per cycle in order.
- R8: Opcode 0 is a NOP. An opcode that does not belong to a slot's unit type is also treated as a NOP, and neither writes anything.
- R9: When several register writebacks reach the same register in one cycle, the highest-numbered slot wins, even when the writebacks come from different latencies. The same rule applies to two stores to the same word.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: BNE=7 is valid only in slot 1. If rs1 != rs2, `branch_taken` is 1 in the cycle after issue and `branch_offset` holds imm. Operations already in flight still complete.
- R12: `dbg_data` shows register `dbg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears registers, memory and pipelines |
| bundle_valid | input | 1 | Bundle present on `bundle_data` |
| bundle_ready | output | 1 | High whenever not in reset (no back-pressure) |
| bundle_data | input | 144 | Six packed operation slots |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Debug register value |
| branch_taken | output | 1 | Taken branch reported one cycle after issue |
| branch_offset | output | 5 | Signed displacement of the last taken branch |

## Verification
The bench samples each destination register in the cycle just before its writeback and again just after it. An engine with a one-cycle latency error therefore shows either the new value too early or the old value too late. It checks a store and a load to the same word issued together, which would return the new data if the store landed early or the load read memory at issue too late. It also checks a consumer that depends on a producer in the same bundle, which a design forwarding within the bundle would get wrong. Write collisions are checked both between two integer slots and between an integer result and an adder result of the same age. In each case a wrong priority leaves the lower slot's value in the register. A final set of checks uses a bubble cycle that carries live operations, wrong-unit opcodes, writes to register 0, and a branch issued while a multiply is still in flight. A design that lets any of these take effect, or that flushes the multiply, shows a value other than the expected one.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RAW    = 5;
  localparam int NSLOT  = 6;
  localparam int SLOT_W = 24;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_ADDI = 4'd6;
  localparam logic [3:0] OP_BNE  = 4'd7;
  localparam logic [3:0] OP_LD   = 4'd8;
  localparam logic [3:0] OP_ST   = 4'd9;
  localparam logic [3:0] OP_FADD = 4'd10;
  localparam logic [3:0] OP_FMUL = 4'd11;

  typedef struct packed {
    logic [3:0]     opc;
    logic [RAW-1:0] rd;
    logic [RAW-1:0] rs1;
    logic [RAW-1:0] rs2;
    logic [4:0]     imm;
  } slot_t;

  typedef enum logic [1:0] {U_INT, U_MEM, U_FADD, U_FMUL} unit_e;

  // In-flight payload carried by a slot's delay line
  typedef struct packed {
    logic           wen;
    logic           lde;
    logic           ste;
    logic [RAW-1:0] rd;
    logic [XLEN-1:0] addr;
    logic [XLEN-1:0] val;
  } flight_t;

  function automatic unit_e unit_of(int s);
    if (s < 2)      return U_INT;
    else if (s < 4) return U_MEM;
    else if (s == 4) return U_FADD;
    else            return U_FMUL;
  endfunction
endpackage

// File: rtl/vliw_slot_exec.sv
module vliw_slot_exec
  import vliw_pkg::*;
#(
  parameter unit_e UNIT   = U_INT,
  parameter bit    BR_OK  = 1'b0
) (
  input  logic            vld,
  input  slot_t           op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output flight_t         iss,
  output logic            br_hit
);
  logic [XLEN-1:0] imm_s;
  logic [XLEN-1:0] res;

  assign imm_s = {{(XLEN-5){op.imm[4]}}, op.imm};

  always_comb begin
    iss      = '0;
    br_hit   = 1'b0;
    res      = '0;
    iss.rd   = op.rd;
    iss.addr = a + imm_s;
    if (vld) begin
      case (UNIT)
        U_INT: begin
          case (op.opc)
            OP_ADD:  begin iss.wen = 1'b1; res = a + b;     end
            OP_SUB:  begin iss.wen = 1'b1; res = a - b;     end
            OP_AND:  begin iss.wen = 1'b1; res = a & b;     end
            OP_OR:   begin iss.wen = 1'b1; res = a | b;     end
            OP_XOR:  begin iss.wen = 1'b1; res = a ^ b;     end
            OP_ADDI: begin iss.wen = 1'b1; res = a + imm_s; end
            OP_BNE:  br_hit = BR_OK && (a != b);
            default: ;
          endcase
        end
        U_MEM: begin
          if (op.opc == OP_LD) iss.lde = 1'b1;
          if (op.opc == OP_ST) iss.ste = 1'b1;
        end
        U_FADD: if (op.opc == OP_FADD) begin iss.wen = 1'b1; res = a + b; end
        U_FMUL: if (op.opc == OP_FMUL) begin iss.wen = 1'b1; res = a * b; end
        default: ;
      endcase
    end
    iss.val = iss.ste ? b : res;
  end
endmodule

// File: rtl/vliw_delay.sv
module vliw_delay #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] pipe [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= din;
          for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign dout = pipe[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vliw_pkg::*;
#(
  parameter int NRD = 13,
  parameter int NWR = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NWR-1:0]                 we,
  input  logic [NWR-1:0][RAW-1:0]        wa,
  input  logic [NWR-1:0][XLEN-1:0]       wd,
  input  logic [NRD-1:0][RAW-1:0]        ra,
  output logic [NRD-1:0][XLEN-1:0]       rdat
);
  logic [XLEN-1:0] regs [NREG];

  // Later ports are applied last, so the highest-numbered writer wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (we[w] && wa[w] != '0) regs[wa[w]] <= wd[w];
    end
  end

  always_comb begin
    for (int p = 0; p < NRD; p++)
      rdat[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end
endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem
  import vliw_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int NPORT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPORT-1:0]           we,
  input  logic [NPORT-1:0][XLEN-1:0] waddr,
  input  logic [NPORT-1:0][XLEN-1:0] wdata,
  input  logic [NPORT-1:0][XLEN-1:0] raddr,
  output logic [NPORT-1:0][XLEN-1:0] rdata
);
  localparam int IW = $clog2(WORDS);
  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (we[p]) mem[waddr[p][IW-1:0]] <= wdata[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) rdata[p] = mem[raddr[p][IW-1:0]];
  end
endmodule

// File: rtl/vliw_bundle_engine.sv
module vliw_bundle_engine
  import vliw_pkg::*;
#(
  parameter int MEM_WORDS = 16,
  parameter int INT_LAT   = 1,
  parameter int MEM_LAT   = 3,
  parameter int FP_LAT    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bundle_valid,
  output logic                      bundle_ready,
  input  logic [NSLOT*SLOT_W-1:0]   bundle_data,
  input  logic [RAW-1:0]            dbg_addr,
  output logic [XLEN-1:0]           dbg_data,
  output logic                      branch_taken,
  output logic [4:0]                branch_offset
);
  localparam int NRD = 2 * NSLOT + 1;
  localparam int NMP = 2;

  logic                          issue;
  slot_t                         sl     [NSLOT];
  logic [NRD-1:0][RAW-1:0]       rf_ra;
  logic [NRD-1:0][XLEN-1:0]      rf_rd;
  logic [NSLOT-1:0]              wb_en;
  logic [NSLOT-1:0][RAW-1:0]     wb_rd;
  logic [NSLOT-1:0][XLEN-1:0]    wb_val;
  logic [NSLOT-1:0]              br_hit;
  logic [NMP-1:0]                m_we;
  logic [NMP-1:0][XLEN-1:0]      m_waddr, m_wdata, m_raddr, m_rdata;

  assign bundle_ready = ~rst;
  assign issue        = bundle_valid & bundle_ready;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam unit_e KIND = unit_of(s);
      localparam int LAT = (KIND == U_INT) ? INT_LAT :
                           (KIND == U_MEM) ? MEM_LAT : FP_LAT;
      localparam int MP  = (s >= 2) ? s - 2 : 0;
      flight_t iss, fin;

      assign sl[s]          = bundle_data[s*SLOT_W +: SLOT_W];
      assign rf_ra[2*s]     = sl[s].rs1;
      assign rf_ra[2*s+1]   = sl[s].rs2;

      vliw_slot_exec #(.UNIT(KIND), .BR_OK(s == 1)) u_exec (
        .vld(issue), .op(sl[s]), .a(rf_rd[2*s]), .b(rf_rd[2*s+1]),
        .iss(iss), .br_hit(br_hit[s])
      );

      vliw_delay #(.DEPTH(LAT-1), .W($bits(flight_t))) u_dly (
        .clk(clk), .rst(rst), .din(iss), .dout(fin)
      );

      assign wb_rd[s] = fin.rd;
      if (KIND == U_MEM) begin : g_mem
        assign wb_en[s]     = fin.lde;
        assign wb_val[s]    = m_rdata[MP];
        assign m_we[MP]     = fin.ste;
        assign m_waddr[MP]  = fin.addr;
        assign m_wdata[MP]  = fin.val;
        assign m_raddr[MP]  = fin.addr;
      end else begin : g_alu
        assign wb_en[s]     = fin.wen;
        assign wb_val[s]    = fin.val;
      end
    end
  endgenerate

  assign rf_ra[NRD-1] = dbg_addr;
  assign dbg_data     = rf_rd[NRD-1];

  vliw_regfile #(.NRD(NRD), .NWR(NSLOT)) u_rf (
    .clk(clk), .rst(rst), .we(wb_en), .wa(wb_rd), .wd(wb_val),
    .ra(rf_ra), .rdat(rf_rd)
  );

  vliw_dmem #(.WORDS(MEM_WORDS), .NPORT(NMP)) u_dmem (
    .clk(clk), .rst(rst), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr(m_raddr), .rdata(m_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      branch_taken  <= 1'b0;
      branch_offset <= '0;
    end else begin
      branch_taken <= br_hit[1];
      if (br_hit[1]) branch_offset <= sl[1].imm;
    end
  end
endmodule

// File: rtl/vliw_engine_chk.sv
module vliw_engine_chk
  import vliw_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    bundle_valid,
  input logic                    bundle_ready,
  input logic [NSLOT*SLOT_W-1:0] bundle_data,
  input logic [RAW-1:0]          dbg_addr,
  input logic [XLEN-1:0]         dbg_data,
  input logic                    branch_taken,
  input logic [4:0]              branch_offset
);
  a_r2_always_ready: assert property (@(posedge clk) disable iff (rst)
    bundle_ready);

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (dbg_addr == '0) |-> (dbg_data == '0));

  a_r11_branch_from_valid: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> $past(bundle_valid));

  a_r11_branch_opcode: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> ($past(bundle_data[SLOT_W+20 +: 4]) == OP_BNE));

  a_r11_branch_offset: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (branch_offset == $past(bundle_data[SLOT_W +: 5])));
endmodule

bind vliw_bundle_engine vliw_engine_chk u_chk (.*);

// File: tb/tb_vliw_bundle_engine.sv
`timescale 1ns/100ps
module tb_vliw_bundle_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bundle_valid = 1'b0;
  logic         bundle_ready;
  logic [143:0] bundle_data = '0;
  logic [4:0]   dbg_addr = '0;
  logic [31:0]  dbg_data;
  logic         branch_taken;
  logic [4:0]   branch_offset;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vliw_bundle_engine dut (.*);

  typedef struct packed { bit kind; logic [4:0] r; logic [31:0] v; } item_t;
  item_t sb_q[$];
  string tag_q[$];

  function automatic logic [23:0] op(input logic [3:0] o, input logic [4:0] rd,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] imm);
    return {o, rd, a, b, imm};
  endfunction

  function automatic logic [143:0] bun(input logic [23:0] s0, s1, s2, s3, s4, s5);
    return {s5, s4, s3, s2, s1, s0};
  endfunction

  task automatic issue(input logic [143:0] b, input logic v = 1'b1);
    @(negedge clk);
    bundle_data  = b;
    bundle_valid = v;
  endtask

  task automatic exp_reg(input logic [4:0] r, input logic [31:0] v, input string tag);
    sb_q.push_back('{1'b0, r, v});
    tag_q.push_back(tag);
  endtask

  task automatic exp_br(input logic t, input logic [4:0] off, input string tag);
    sb_q.push_back('{1'b1, 5'd0, {26'd0, t, off}});
    tag_q.push_back(tag);
  endtask

  // Monitor: checks the state a bundle sees, i.e. after the previous edge
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (sb_q.size() > 0) begin
        item_t it;
        string tg;
        logic [31:0] act;
        it = sb_q.pop_front();
        tg = tag_q.pop_front();
        if (it.kind == 1'b0) begin
          dbg_addr = it.r;
          #0.1;
          act = dbg_data;
        end else begin
          act = {26'd0, branch_taken, branch_offset};
        end
        checks++;
        if (act !== it.v) begin
          failures++;
          $display("FAIL %s reg=%0d actual=%h expected=%h", tg, it.r, act, it.v);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    checks++;
    if (bundle_ready !== 1'b1) begin
      failures++;
      $display("FAIL R2 ready actual=%b expected=1", bundle_ready);
    end
    // c0
    issue(bun(op(6,1,0,0,5), op(6,2,0,0,5'h1D), 0, 0, 0, 0));
    exp_reg(1, 0, "R12 reset r1"); exp_reg(2, 0, "R12 reset r2"); exp_br(0, 0, "R11 reset");
    // c1
    issue(bun(op(1,4,1,2,0), op(2,5,1,2,0), op(9,0,0,1,2), op(8,8,0,0,2),
              op(10,6,1,1,0), op(11,7,1,2,0)));
    exp_reg(1, 5, "R3 addi"); exp_reg(2, 32'hFFFFFFFD, "R3 addi neg");
    // c2
    issue(bun(op(6,10,0,0,7), op(1,11,10,0,0), op(8,12,0,0,2), 0, op(10,14,1,1,0), 0));
    exp_reg(4, 2, "R3 add"); exp_reg(5, 8, "R3 sub");
    exp_reg(6, 0, "R7 fadd stale"); exp_reg(7, 0, "R7 fmul stale");
    // c3
    issue('0);
    exp_reg(10, 7, "R3 addi"); exp_reg(11, 0, "R6 same-bundle old value");
    exp_reg(12, 0, "R4 load stale"); exp_reg(6, 0, "R5 fadd stale");
    // c4
    issue(bun(op(6,13,0,0,1), op(6,13,0,0,2), 0, 0, 0, 0));
    exp_reg(8, 0, "R4 load with same-age store"); exp_reg(6, 0, "R5 not before 4 cycles");
    // c5
    issue(bun(op(6,0,0,0,5), op(6,14,0,0,9), 0, 0, 0, 0));
    exp_reg(6, 10, "R5 fadd"); exp_reg(7, 32'hFFFFFFF1, "R5 fmul");
    exp_reg(12, 5, "R4 load after store"); exp_reg(13, 2, "R9 higher slot wins");
    // c6
    issue(bun(op(6,15,0,0,3), op(7,0,1,2,5'h1C), 0, 0, 0, op(11,16,1,5,0)));
    exp_reg(14, 10, "R9 cross-latency priority"); exp_reg(0, 0, "R10 r0 discard");
    // c7
    issue(bun(0, op(7,0,1,1,3), 0, 0, 0, 0));
    exp_br(1, 5'h1C, "R11 taken"); exp_reg(15, 3, "R7 issue continues");
    // c8: bubble carrying live operations
    issue(bun(op(6,17,0,0,7), 0, op(9,0,0,1,5), 0, 0, 0), 1'b0);
    exp_br(0, 5'h1C, "R11 equal not taken");
    // c9
    issue(bun(0, 0, op(9,0,0,1,3), op(9,0,0,2,3), 0, 0));
    exp_reg(17, 0, "R2 invalid bundle ignored"); exp_reg(16, 0, "R5 fmul stale");
    exp_br(0, 5'h1C, "R2 no branch from bubble");
    // c10
    issue(bun(op(8,19,0,0,1), 0, op(8,18,0,0,3), op(8,20,1,0,5'h1E), op(1,21,1,1,0), 0));
    exp_reg(16, 40, "R11 in-flight op completes");
    // c11
    issue('0);
    exp_reg(19, 0, "R8 wrong-unit op in int slot");
    // c12
    issue('0);
    exp_reg(18, 0, "R4 load not before 3 cycles");
    // c13
    issue('0);
    exp_reg(18, 32'hFFFFFFFD, "R9 second store wins");
    exp_reg(20, 32'hFFFFFFFD, "R4 negative offset");
    exp_reg(21, 0, "R8 wrong-unit op in adder slot");
    issue('0);
    issue('0);
    @(negedge clk);
    #2.0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule